// File: doc/BRIEF.md
# Burst-Buffered SPI Master

This block is an SPI master that software drives through a small register window. A single write to the control register starts one of three transfers. The first moves one byte. The second moves a short burst that fills one 64-bit buffer word. The third moves a full burst that covers every buffer word. Every transfer is full duplex. Each byte that arrives from the slave replaces, in the buffer, the byte that was just sent. Software therefore reads its results from the same registers it loaded. To receive only, software loads the buffers with all ones first.

Software starts a transfer and then polls one busy bit. When busy clears, it reads the received data back. The chip-select level and the serial clock divisor both live in the control register. Chip select keeps whatever level software last wrote, so several transfers can run back to back inside one frame.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, `spi_sclk` is 0, `spi_cs_n` is 1, and every register reads as zero. This includes the busy bit.
- R2: A control write with size code 1 sends the byte register (offset 0x04), MSB first. The byte received from the slave then replaces the byte register.
- R3: Size code 2 sends the eight bytes of burst word 0 (offset 0x08), least significant byte first and MSB first within each byte. The received bytes replace word 0 in place. Burst words 1 to 3 stay unchanged.
- R4: Size code 3 sends all 32 bytes, taking word 0 first, then 1, 2 and 3 (offsets 0x08, 0x10, 0x18, 0x20). The byte order inside each word is the same as in R3. The received bytes replace all four words.
- R5: The bus runs in SPI mode 0. `spi_sclk` idles low and MISO is sampled on its rising edge. MOSI changes only while `spi_sclk` is low. Within a byte, one `spi_sclk` period lasts 2*(DIV+1) system clocks, where DIV is control bits [15:8].
- R6: Control bit 31 (busy) reads 1 from the cycle after an accepted start until the last byte is stored. A transfer of N bytes gives exactly 8*N rising edges of `spi_sclk`.
- R7: `spi_cs_n` is the inverse of control bit 2 as last accepted. It stays low across back-to-back transfers until software clears the bit.
- R8: While busy is 1, writes to the control register, the byte register and the burst words have no effect. Chip select, transfer length and buffer contents all stay as they were.
- R9: A read presents its data on `reg_rdata` one cycle after `reg_rd`. The control register reads back bit 2 and bits [15:8] as last written, and the data registers read back their contents.
- R10: A control write with size code 0, while not busy, updates chip select and the divisor but starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data, registered |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
A software write to the buffers or the control register can land in a cycle where the shift engine is also writing a received byte back into the buffer. The bench provokes this by issuing writes to word 0, word 1, the byte register and the control register while a short burst runs. It then checks four things: the slave still saw exactly 64 clock edges, chip select never moved, word 1 kept its value, and word 0 holds exactly the bytes the slave model sent. Divisor sweeps show separately whether the period and the bit order survive at every speed.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int CTRL_OFS  = 0;
  localparam int BYTE_OFS  = 4;
  localparam int BURST_OFS = 8;
  localparam int CS_BIT    = 2;
  localparam int DIV_LSB   = 8;
  localparam int BUSY_BIT  = 31;

  typedef enum logic [1:0] {
    SZ_NONE  = 2'd0,
    SZ_BYTE  = 2'd1,
    SZ_SHORT = 2'd2,
    SZ_FULL  = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en) cnt <= (cnt == div) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       tick,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       done
);
  logic [7:0] sr;
  logic       samp;
  logic [2:0] bcnt;

  assign mosi    = sr[7];
  assign rx_byte = sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      sclk <= 1'b0;
      samp <= 1'b0;
      bcnt <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sr   <= load_byte;
        sclk <= 1'b0;
        bcnt <= '0;
      end else if (tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
          samp <= miso;
        end else begin
          sclk <= 1'b0;
          sr   <= {sr[6:0], samp};
          bcnt <= bcnt + 1'b1;
          done <= (bcnt == 3'd7);
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_buf.sv
module spi_burst_buf #(
  parameter int NREG   = 4,
  parameter int WORD_W = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             sw_we,
  input  logic [$clog2(NREG)-1:0]          sw_sel,
  input  logic [WORD_W-1:0]                sw_data,
  input  logic [$clog2(NREG)-1:0]          rd_sel,
  output logic [WORD_W-1:0]                rd_word,
  input  logic                             eng_we,
  input  logic [$clog2(NREG*WORD_W/8)-1:0] eng_wr_idx,
  input  logic [7:0]                       eng_wr_byte,
  input  logic [$clog2(NREG*WORD_W/8)-1:0] eng_rd_idx,
  output logic [7:0]                       eng_rd_byte
);
  localparam int BPW    = WORD_W / 8;
  localparam int IDX_W  = $clog2(NREG * BPW);
  localparam int SEL_W  = $clog2(NREG);
  localparam int LANE_W = $clog2(BPW);

  logic [WORD_W-1:0] mem [NREG];

  logic [SEL_W-1:0]  wr_word, rd_word_sel;
  logic [LANE_W-1:0] wr_lane, rd_lane;

  assign wr_word     = eng_wr_idx[IDX_W-1:LANE_W];
  assign wr_lane     = eng_wr_idx[LANE_W-1:0];
  assign rd_word_sel = eng_rd_idx[IDX_W-1:LANE_W];
  assign rd_lane     = eng_rd_idx[LANE_W-1:0];

  assign rd_word     = mem[rd_sel];
  assign eng_rd_byte = mem[rd_word_sel][{rd_lane, 3'b000} +: 8];

  for (genvar w = 0; w < NREG; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) mem[w] <= '0;
      else if (eng_we && wr_word == SEL_W'(w)) mem[w][{wr_lane, 3'b000} +: 8] <= eng_wr_byte;
      else if (sw_we && sw_sel == SEL_W'(w)) mem[w] <= sw_data;
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int WORD_W = 64,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int BPW    = WORD_W / 8;
  localparam int TOTAL  = NREG * BPW;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam int SEL_W  = $clog2(NREG);
  localparam int LANE_W = $clog2(BPW);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(BYTE_OFS);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(BURST_OFS);
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(BURST_OFS + TOTAL);

  // register state
  logic             running, single_mode, cs_n_q;
  logic [IDX_W-1:0] byte_idx, last_idx;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       single_q;

  // decode
  logic             is_ctrl, is_byte, burst_hit;
  logic [SEL_W-1:0] burst_sel;
  logic [ADDR_W-1:0] burst_off;
  xfer_size_e       cmd_size;

  assign is_ctrl   = (reg_addr == A_CTRL);
  assign is_byte   = (reg_addr == A_BYTE);
  assign burst_off = reg_addr - A_BASE;
  assign burst_hit = (reg_addr >= A_BASE) && (reg_addr < A_END) &&
                     (reg_addr[LANE_W-1:0] == '0);
  assign burst_sel = burst_off[LANE_W +: SEL_W];
  assign cmd_size  = xfer_size_e'(reg_wdata[1:0]);

  // engine control
  logic             ctrl_ok, start, sh_done, done_evt, last, load, tick_en, tick, use_single;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       buf_tx, load_byte, rx_byte;
  logic [WORD_W-1:0] buf_word;

  assign ctrl_ok    = reg_wr && is_ctrl && !running;
  assign start      = ctrl_ok && (cmd_size != SZ_NONE);
  assign done_evt   = running && sh_done;
  assign last       = (byte_idx == last_idx);
  assign load       = start || (done_evt && !last);
  assign rd_idx     = start ? '0 : byte_idx + 1'b1;
  assign use_single = start ? (cmd_size == SZ_BYTE) : single_mode;
  assign load_byte  = use_single ? single_q : buf_tx;
  assign tick_en    = running && !sh_done && !load;

  spi_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(load || !running), .en(tick_en),
    .div(div_q), .tick(tick)
  );

  spi_byte_shifter u_shift (
    .clk(clk), .rst(rst), .load(load), .load_byte(load_byte), .tick(tick),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(rx_byte),
    .done(sh_done)
  );

  spi_burst_buf #(.NREG(NREG), .WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst(rst),
    .sw_we(reg_wr && burst_hit && !running), .sw_sel(burst_sel), .sw_data(reg_wdata),
    .rd_sel(burst_sel), .rd_word(buf_word),
    .eng_we(done_evt && !single_mode), .eng_wr_idx(byte_idx), .eng_wr_byte(rx_byte),
    .eng_rd_idx(rd_idx), .eng_rd_byte(buf_tx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      single_mode <= 1'b0;
      byte_idx    <= '0;
      last_idx    <= '0;
      cs_n_q      <= 1'b1;
      div_q       <= '0;
      single_q    <= '0;
    end else begin
      if (ctrl_ok) begin
        cs_n_q <= ~reg_wdata[CS_BIT];
        div_q  <= reg_wdata[DIV_LSB +: DIV_W];
      end
      if (start) begin
        running     <= 1'b1;
        single_mode <= (cmd_size == SZ_BYTE);
        byte_idx    <= '0;
        case (cmd_size)
          SZ_SHORT: last_idx <= IDX_W'(BPW - 1);
          SZ_FULL:  last_idx <= IDX_W'(TOTAL - 1);
          default:  last_idx <= '0;
        endcase
      end else if (done_evt) begin
        if (last) running <= 1'b0;
        else      byte_idx <= byte_idx + 1'b1;
      end
      if (reg_wr && is_byte && !running) single_q <= reg_wdata[7:0];
      else if (done_evt && single_mode)  single_q <= rx_byte;
    end
  end

  assign spi_cs_n = cs_n_q;

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      reg_rdata <= '0;
      if (is_ctrl) begin
        reg_rdata[BUSY_BIT]              <= running;
        reg_rdata[CS_BIT]                <= ~cs_n_q;
        reg_rdata[DIV_LSB +: DIV_W]      <= div_q;
      end else if (is_byte) begin
        reg_rdata[7:0] <= single_q;
      end else if (burst_hit) begin
        reg_rdata <= buf_word;
      end
    end
  end
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              running,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic              spi_cs_n
);
  // R5: data line moves only while the serial clock is low
  a_r5_mosi_moves_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_mosi) |-> !spi_sclk);

  // R6: serial clock rests low whenever no transfer runs
  a_r6_idle_sclk_low: assert property (@(posedge clk) disable iff (rst)
    !running |-> !spi_sclk);

  // R6: an accepted start raises busy on the next cycle
  a_r6_start_busy: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == '0 && reg_wdata[1:0] != 2'b00 && !running) |=> running);

  // R8: a control write during a transfer leaves chip select alone
  a_r8_cs_held: assert property (@(posedge clk) disable iff (rst)
    (running && reg_wr) |=> $stable(spi_cs_n));
endmodule

bind spi_burst_master spi_burst_master_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .running(running), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/sim_spi_burst_master.sv
`timescale 1ns/1ps
module sim_spi_burst_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  always #10 clk = ~clk;

  spi_burst_master u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int checks = 0, failures = 0, cyc = 0;
  // slave model
  int negc = 0, posc = 0, perr = 0, seed = 0, csrise = 0;
  longint exp_per = 40, lastrise = 0;
  logic [7:0]  mo [32];
  logic [63:0] mbuf [4];
  logic [7:0]  mbyte;

  function automatic logic [7:0] sb(input int k, input int s);
    return 8'((k * 29 + s) ^ 8'h5A);
  endfunction

  assign spi_miso = sb(negc / 8, seed)[7 - (negc % 8)];

  always @(negedge spi_sclk) negc++;
  always @(posedge spi_sclk) begin
    mo[posc / 8] = {mo[posc / 8][6:0], spi_mosi};
    if ((posc % 8) != 0 && ($time - lastrise) != exp_per) perr++;
    lastrise = $time;
    posc++;
  end
  always @(posedge spi_cs_n) csrise++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired: actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [63:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(6'h00, v);
      if (!v[31]) break;
    end
  endtask

  task automatic launch(input int sz, input int dv, input int sd, input bit cs);
    negc = 0; posc = 0; perr = 0; seed = sd;
    exp_per = 40 * (dv + 1);
    wr(6'h00, (64'(dv) << 8) | (64'(cs) << 2) | 64'(sz));
  endtask

  // check the serial stream and the readback after a transfer of size sz
  task automatic verify(input int sz, input string req);
    int n, bad;
    logic [63:0] v;
    n = (sz == 1) ? 1 : (sz == 2) ? 8 : 32;
    chk(posc == 8 * n, "R6 edge count", posc, 8 * n);
    chk(perr == 0, "R5 sclk period", perr, 0);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = (sz == 1) ? mbyte : mbuf[k / 8][(k % 8) * 8 +: 8];
      if (mo[k] != e) bad++;
    end
    chk(bad == 0, {req, " mosi bytes"}, bad, 0);
    for (int k = 0; k < n; k++) begin
      if (sz == 1) mbyte = sb(k, seed);
      else mbuf[k / 8][(k % 8) * 8 +: 8] = sb(k, seed);
    end
    if (sz == 1) begin
      rd(6'h04, v);
      chk(v == {56'b0, mbyte}, {req, " rx byte"}, v, {56'b0, mbyte});
    end else begin
      for (int w = 0; w < 4; w++) begin
        rd(6'(8 + 8 * w), v);
        chk(v == mbuf[w], {req, " rx word"}, v, mbuf[w]);
      end
    end
  endtask

  task automatic load_words(input int s);
    for (int w = 0; w < 4; w++) begin
      mbuf[w] = {32'(s * 7 + w), 32'hC3A5_0F00 ^ 32'(w * 1234567)};
      wr(6'(8 + 8 * w), mbuf[w]);
    end
  endtask

  initial begin
    logic [63:0] v;
    mbyte = '0;
    for (int w = 0; w < 4; w++) mbuf[w] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(spi_sclk == 1'b0 && spi_cs_n == 1'b1, "R1 pins", {spi_sclk, spi_cs_n}, 2'b01);
    rd(6'h00, v); chk(v == 0, "R1 ctrl", v, 0);
    for (int w = 0; w < 4; w++) begin
      rd(6'(8 + 8 * w), v); chk(v == 0, "R1 word", v, 0);
    end
    // R9 readback
    load_words(1);
    for (int w = 0; w < 4; w++) begin
      rd(6'(8 + 8 * w), v); chk(v == mbuf[w], "R9 word readback", v, mbuf[w]);
    end
    // R10 size 0 updates ctrl only
    negc = 0; posc = 0;
    wr(6'h00, 64'h0000_0504);
    rd(6'h00, v); chk(v == 64'h0504, "R9 R10 ctrl readback", v, 64'h0504);
    repeat (40) @(negedge clk);
    chk(posc == 0 && spi_cs_n == 1'b0, "R10 no transfer", {posc[7:0], spi_cs_n}, 0);
    // R2 single byte sweep over divisors and patterns
    for (int dv = 0; dv < 4; dv++) begin
      for (int p = 0; p < 3; p++) begin
        mbyte = 8'(p * 91 + dv * 17 + 1);
        wr(6'h04, {56'hFFFF_FFFF_FFFF_FF, mbyte});
        launch(1, dv, p + 3 * dv, 1);
        rd(6'h00, v); chk(v[31] == 1'b1, "R6 busy after start", v[31], 1);
        wait_idle();
        verify(1, "R2");
      end
    end
    // R3 short bursts
    for (int dv = 0; dv < 3; dv++) begin
      load_words(dv + 10);
      launch(2, dv, 40 + dv, 1);
      wait_idle();
      verify(2, "R3");
    end
    // R4 full bursts, including receive-only with all ones
    load_words(20);
    launch(3, 0, 77, 1); wait_idle(); verify(3, "R4");
    for (int w = 0; w < 4; w++) begin mbuf[w] = '1; wr(6'(8 + 8 * w), '1); end
    launch(3, 1, 90, 1); wait_idle(); verify(3, "R4 receive-only");
    // R7 back to back with chip select held low
    csrise = 0;
    load_words(30);
    launch(2, 0, 5, 1); wait_idle(); verify(2, "R7 first");
    launch(2, 2, 6, 1); wait_idle(); verify(2, "R7 second");
    chk(csrise == 0 && spi_cs_n == 1'b0, "R7 cs held", csrise, 0);
    wr(6'h00, 64'h0);
    chk(spi_cs_n == 1'b1, "R7 cs release", spi_cs_n, 1);
    // R8 writes during busy are ignored
    load_words(50);
    mbyte = 8'h6E; wr(6'h04, 64'h6E);
    launch(2, 3, 61, 1);
    wr(6'h10, 64'hDEAD_BEEF_0000_1111);
    wr(6'h08, 64'h1234_5678_9ABC_DEF0);
    wr(6'h04, 64'h33);
    wr(6'h00, 64'h0000_0003);
    chk(spi_cs_n == 1'b0, "R8 cs unchanged", spi_cs_n, 0);
    wait_idle();
    verify(2, "R8");
    rd(6'h04, v); chk(v == 64'h6E, "R8 byte reg", v, 64'h6E);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule